// File: doc/BRIEF.md
# Stencil Line Buffer with Edge Replication

This block sits in front of the arithmetic of a raster-scan neighbourhood processor that works with a square window of radius `RADIUS`. Cells of a frame arrive one per handshake in row-major order. Each cell carries a state value, a per-cell constant and a template-select code. For every cell of the frame the block presents one vertical column of `2*RADIUS+1` state values centred on that cell. It also presents the constant and template-select values that belong to the centre cell. This lets a downstream window engine build the full neighbourhood with one external load and one external store per cell.

State is held in a chain of `2*RADIUS` full-width line delays. Together with the incoming value they give `2*RADIUS+1` vertically aligned taps. Constant and select values go through `RADIUS` line delays, so they come out together with the centre row. Rows outside the frame take the value of the nearest edge row. At the top this comes from writing the first row into every state line delay at once. At the bottom the newest buffered row is fed back while `RADIUS` extra rows drain out with no input.

Top module: `stencil_linebuf`

## Requirements
- R1: After reset is released, `out_valid` is low and `in_ready` is high.
- R2: The first `RADIUS` rows of a frame are accepted without any output. The first output column appears in the cycle in which the first cell of row `RADIUS` is offered.
- R3: For centre cell (r, c), slice k of `out_col` (bits `k*STATE_W` upward, k = 0 topmost) holds the state value of row r-RADIUS+k, column c.
- R4: A row index below 0 in R3 is replaced by row 0.
- R5: Once the last cell of a frame is taken, `in_ready` stays low while `RADIUS` more rows of columns are emitted. A row index above HEIGHT-1 is replaced by row HEIGHT-1.
- R6: `out_const` and `out_tsel` equal the constant and select values that were supplied with the centre cell (r, c).
- R7: Each frame yields exactly WIDTH*HEIGHT output columns in row-major order, and no output is ever emitted ahead of its input.
- R8: While `out_valid` is high and `out_ready` is low, no input is accepted. While draining, the presented column holds steady.
- R9: The columns of a frame depend only on that frame's own cells; nothing carries over from the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming cell is present |
| in_ready | output | 1 | Block accepts the incoming cell |
| in_state | input | STATE_W | State value of the incoming cell |
| in_const | input | CONST_W | Constant of the incoming cell |
| in_tsel | input | TSEL_W | Template-select code of the incoming cell |
| out_valid | output | 1 | An output column is presented |
| out_ready | input | 1 | Consumer takes the output column |
| out_col | output | (2*RADIUS+1)*STATE_W | Vertical state column, slice 0 topmost |
| out_const | output | CONST_W | Constant of the centre cell |
| out_tsel | output | TSEL_W | Template-select code of the centre cell |

## Verification
The bench builds the block with RADIUS=2, WIDTH=5, HEIGHT=6, STATE_W=8, CONST_W=4 and TSEL_W=3. Six rows with a radius of two give two rows clamped at the top, two interior rows and two rows clamped at the bottom, so R3, R4 and R5 each get columns of their own. The narrow width keeps two back-to-back frames short. Those two frames show that the preload fully replaces the previous frame. Back-pressure is applied once while rows are still streaming in and once during the drain.

// File: rtl/stencil_pkg.sv
// Shared helpers for the stencil line buffer.
// Assumes: only constant (elaboration-time) use of the functions below.
package stencil_pkg;

    // Bits needed for a counter that takes values 0 .. count-1 (at least 1).
    function automatic int cnt_bits(input int count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/stencil_line.sv
// One full-width line delay: a DEPTH-stage shift register that advances on en.
// dout is the value written DEPTH advances ago, i.e. the same column one row back.
// Assumes: data storage needs no reset; contents are overwritten before use.
module stencil_line #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] stage [DEPTH];

    // Shift the whole line by one cell on each advance.
    always_ff @(posedge clk) begin
        if (en) begin
            stage[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/stencil_seq.sv
// Frame sequencer: tracks column and row (including RADIUS drain rows),
// derives both handshakes and the advance, preload and drain controls.
// Assumes: HEIGHT >= 1, RADIUS >= 1, cells arrive in row-major order.
module stencil_seq #(
    parameter int WIDTH  = 16,
    parameter int HEIGHT = 16,
    parameter int RADIUS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic advance,
    output logic preload,
    output logic drain
);

    localparam int CBITS = stencil_pkg::cnt_bits(WIDTH);
    localparam int RBITS = stencil_pkg::cnt_bits(HEIGHT + RADIUS);
    localparam logic [CBITS-1:0] COL_LAST = CBITS'(WIDTH - 1);
    localparam logic [RBITS-1:0] ROW_LAST = RBITS'(HEIGHT + RADIUS - 1);
    localparam logic [RBITS-1:0] ROW_END  = RBITS'(HEIGHT);
    localparam logic [RBITS-1:0] ROW_PRIM = RBITS'(RADIUS);

    logic [CBITS-1:0] col;
    logic [RBITS-1:0] row;
    logic             priming;
    logic             take_in;

    // Phase decode from the row counter.
    assign priming   = (row < ROW_PRIM);
    assign drain     = (row >= ROW_END);
    assign preload   = (row == '0);
    assign in_ready  = !drain && (priming || out_ready);
    assign take_in   = in_valid && in_ready;
    assign out_valid = !priming && (drain || in_valid);
    assign advance   = take_in || (drain && (priming || out_ready));

    // Step column and row on every advance, wrapping at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (advance) begin
            if (col == COL_LAST) begin
                col <= '0;
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end else begin
                col <= col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stencil_linebuf.sv
// Stencil line buffer: 2*RADIUS state line delays give 2*RADIUS+1 aligned taps;
// RADIUS side line delays align constant and select with the centre row.
// Top edge: row 0 is written into every state line. Bottom edge: the newest
// line is fed back as the incoming row while RADIUS rows drain.
// Assumes: WIDTH cells per row, HEIGHT rows per frame, row-major input order.
module stencil_linebuf #(
    parameter int RADIUS  = 2,
    parameter int WIDTH   = 16,
    parameter int HEIGHT  = 16,
    parameter int STATE_W = 8,
    parameter int CONST_W = 8,
    parameter int TSEL_W  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [STATE_W-1:0]               in_state,
    input  logic [CONST_W-1:0]               in_const,
    input  logic [TSEL_W-1:0]                in_tsel,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [(2*RADIUS+1)*STATE_W-1:0]  out_col,
    output logic [CONST_W-1:0]               out_const,
    output logic [TSEL_W-1:0]                out_tsel
);

    localparam int TAPS   = 2*RADIUS + 1;
    localparam int NLINES = 2*RADIUS;
    localparam int SIDE_W = CONST_W + TSEL_W;

    logic               advance;
    logic               preload;
    logic               drain;
    logic [STATE_W-1:0] tap  [TAPS];
    logic [SIDE_W-1:0]  side [RADIUS+1];

    stencil_seq #(
        .WIDTH  (WIDTH),
        .HEIGHT (HEIGHT),
        .RADIUS (RADIUS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .advance   (advance),
        .preload   (preload),
        .drain     (drain)
    );

    // Newest row: live input, or the last buffered row while draining.
    assign tap[0] = drain ? tap[1] : in_state;

    // State line chain; row 0 is written into all lines at frame start.
    for (genvar l = 0; l < NLINES; l++) begin : g_state
        logic [STATE_W-1:0] feed;
        assign feed = preload ? in_state : tap[l];
        stencil_line #(.DEPTH(WIDTH), .DW(STATE_W)) u_line (
            .clk  (clk),
            .en   (advance),
            .din  (feed),
            .dout (tap[l+1])
        );
    end

    // Constant and select chain, RADIUS rows deep.
    assign side[0] = drain ? '0 : {in_const, in_tsel};
    for (genvar l = 0; l < RADIUS; l++) begin : g_side
        stencil_line #(.DEPTH(WIDTH), .DW(SIDE_W)) u_line (
            .clk  (clk),
            .en   (advance),
            .din  (side[l]),
            .dout (side[l+1])
        );
    end
    assign {out_const, out_tsel} = side[RADIUS];

    // Slice k (top first) takes the tap holding row r-RADIUS+k.
    for (genvar k = 0; k < TAPS; k++) begin : g_out
        assign out_col[k*STATE_W +: STATE_W] = tap[NLINES-k];
    end

endmodule

// File: rtl/stencil_linebuf_chk.sv
// Protocol checker for stencil_linebuf, attached with bind below.
// Counts cells taken and columns emitted within the current frame.
module stencil_linebuf_chk #(
    parameter int RADIUS  = 2,
    parameter int WIDTH   = 16,
    parameter int HEIGHT  = 16,
    parameter int STATE_W = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            in_valid,
    input logic                            in_ready,
    input logic                            out_valid,
    input logic                            out_ready,
    input logic [(2*RADIUS+1)*STATE_W-1:0] out_col
);

    localparam logic [31:0] FRAME = 32'(WIDTH*HEIGHT);
    localparam logic [31:0] PRIME = 32'(RADIUS*WIDTH);

    logic [31:0] acc_in;
    logic [31:0] acc_out;
    logic        in_fire;
    logic        out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Per-frame counters of accepted cells and emitted columns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_in  <= '0;
            acc_out <= '0;
        end else if (out_fire && acc_out == FRAME - 1) begin
            acc_in  <= '0;
            acc_out <= '0;
        end else begin
            acc_in  <= acc_in + 32'(in_fire);
            acc_out <= acc_out + 32'(out_fire);
        end
    end

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    p_primed_before_output_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (acc_in >= PRIME));

    p_frame_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in == FRAME) |-> !in_ready);

    p_output_lags_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire |-> ((acc_out < acc_in) || in_fire));

    p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    p_stall_holds_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_col)));

endmodule

bind stencil_linebuf stencil_linebuf_chk #(
    .RADIUS  (RADIUS),
    .WIDTH   (WIDTH),
    .HEIGHT  (HEIGHT),
    .STATE_W (STATE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_col   (out_col)
);

// File: tb/stencil_linebuf_test.sv
`timescale 1ns/1ps
// Bench: two frames from a stimulus table, every column compared with a
// clamped-window model, plus directed reset, priming, drain and stall checks.
module stencil_linebuf_test;

    localparam int R     = 2;
    localparam int W     = 5;
    localparam int H     = 6;
    localparam int SW    = 8;
    localparam int CELLS = W*H;
    localparam int TAPS  = 2*R + 1;

    localparam logic [7:0] TBL [CELLS] = '{
        8'd3,   8'd41,  8'd200, 8'd17,  8'd99,
        8'd250, 8'd0,   8'd66,  8'd128, 8'd7,
        8'd54,  8'd181, 8'd33,  8'd90,  8'd222,
        8'd12,  8'd77,  8'd140, 8'd255, 8'd5,
        8'd61,  8'd118, 8'd39,  8'd204, 8'd88,
        8'd150, 8'd26,  8'd173, 8'd9,   8'd231
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [SW-1:0]        in_state = '0;
    logic [3:0]           in_const = '0;
    logic [2:0]           in_tsel = '0;
    logic                 out_valid;
    logic                 out_ready = 1'b1;
    logic [TAPS*SW-1:0]   out_col;
    logic [3:0]           out_const;
    logic [2:0]           out_tsel;

    int errors = 0;
    int checks = 0;
    int out_cnt = 0;
    logic [TAPS*SW-1:0] snap;

    always #4 clk = ~clk;

    stencil_linebuf #(
        .RADIUS (R), .WIDTH (W), .HEIGHT (H),
        .STATE_W (SW), .CONST_W (4), .TSEL_W (3)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_state (in_state), .in_const (in_const), .in_tsel (in_tsel),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_col (out_col), .out_const (out_const), .out_tsel (out_tsel)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int fr, input int r, input int c);
        int v = int'(TBL[r*W + c]);
        return (fr == 0) ? 8'(v) : 8'(v*7 + 91);
    endfunction

    function automatic int clampr(input int r);
        return (r < 0) ? 0 : ((r > H-1) ? H-1 : r);
    endfunction

    function automatic logic [TAPS*SW-1:0] exp_col(input int fr, input int r, input int c);
        logic [TAPS*SW-1:0] e;
        for (int k = 0; k < TAPS; k++) e[k*SW +: SW] = pix(fr, clampr(r - R + k), c);
        return e;
    endfunction

    // Model check of every column taken by the consumer.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            automatic int fr  = out_cnt / CELLS;
            automatic int idx = out_cnt % CELLS;
            automatic int r   = idx / W;
            automatic int c   = idx % W;
            automatic string tag = (fr == 1) ? "R9" : (r < R) ? "R4" : (r >= H-R) ? "R5" : "R3";
            automatic logic [TAPS*SW-1:0] e = exp_col(fr, r, c);
            automatic logic [6:0] es = {4'(idx*3 + fr), 3'(idx + 2*fr)};
            chk(out_col == e, tag, 64'(out_col), 64'(e));
            chk({out_const, out_tsel} == es, "R6", 64'({out_const, out_tsel}), 64'(es));
            out_cnt++;
        end
    end

    task automatic drive(input int fr, input int i);
        in_valid = 1'b1;
        in_state = pix(fr, i / W, i % W);
        in_const = 4'(i*3 + fr);
        in_tsel  = 3'(i + 2*fr);
    endtask

    // Wait for acceptance, leave 1 ns after the accepting edge.
    task automatic take();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic finish_frame(input int target);
        while (out_cnt < target) @(posedge clk);
        repeat (3) @(posedge clk);
        #3;
        chk(out_cnt == target, "R7", 64'(out_cnt), 64'(target));
        chk(out_valid == 1'b0, "R7", 64'(out_valid), 64'd0);
        #5;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);
        @(posedge clk);
        #1;

        // Frame 0: free-flowing consumer.
        for (int i = 0; i < CELLS; i++) begin
            drive(0, i);
            if (i == R*W) begin
                #2;
                chk(out_cnt == 0, "R2", 64'(out_cnt), 64'd0);
                chk(out_valid == 1'b1, "R2", 64'(out_valid), 64'd1);
            end
            take();
        end
        #2;
        chk(in_ready == 1'b0, "R5", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b1, "R5", 64'(out_valid), 64'd1);
        finish_frame(CELLS);

        // Frame 1: new data, stall mid-stream and during drain.
        @(posedge clk);
        #1;
        for (int i = 0; i < CELLS; i++) begin
            drive(1, i);
            if (i == 12) begin
                out_ready = 1'b0;
                #2;
                chk(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
                snap = out_col;
                @(posedge clk);
                #3;
                chk(out_valid == 1'b1 && out_col == snap, "R8", 64'(out_col), 64'(snap));
                @(posedge clk);
                #1 out_ready = 1'b1;
            end
            take();
        end
        out_ready = 1'b0;
        #2;
        chk(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
        snap = out_col;
        repeat (2) @(posedge clk);
        #3;
        chk(out_valid == 1'b1 && out_col == snap, "R8", 64'(out_col), 64'(snap));
        @(posedge clk);
        #1 out_ready = 1'b1;
        finish_frame(2*CELLS);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8*20000);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=%0d columns expected=%0d", out_cnt, 2*CELLS);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule